// File: doc/BRIEF.md
# Display Interrupt Status Aggregator

This block collects the event pulses raised by a display frame engine and keeps them in two sticky status registers. The engine serves up to seven fetch channels. Channel 0 reports into the first status word. Channels 1 and up report into the second status word at positions derived from the channel number. Two control words hold the per-source masks, an enable bit and a disable-after-frame bit. A single level interrupt line is raised whenever any unmasked status bit is set.

When the first unmasked start-of-frame, end-of-frame or branch event arrives, or any bus error arrives, while the line is low, the block copies that channel's frame ID into an interrupt-ID register. Software can then tell which frame caused the interrupt. If such an event arrives while the line is already high, a "second interrupt" flag is set instead and the captured ID is kept. Software clears status bits by writing ones to them.

The register port is a simple single-cycle write strobe with a register select, plus a combinational read select.

Top module: `dirq_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The select codes are 0 = control 0, 1 = control 5, 2 = status 0, 3 = status 1 and 4 = interrupt ID. Any other select reads zero.
- R2: `irq` is registered. One clock after the status or masks change, it equals the OR of two terms: the status-0 bits 0, 1, 4, 5, 6, 7, 8, 9, 11 and 12 each gated by its clear mask bit, and status 1 ANDed with the inverse of control 5. The status-0 mask bits are in control 0 at bits 3, 4, 5, 21, 11, 6, 20, 23 and 24 for status bits 0, 1, 4, 6, 7, 8, 9, 11 and 12. Status bit 5 is masked by control 5 bit 24.
- R3: Channel 0 start-of-frame sets status-0 bit 1, end-of-frame sets bit 8 and branch sets bit 9. Start-of-frame and end-of-frame take effect only while that channel's `sof_int_en` or `eof_int_en` input is high.
- R4: For channel c from 1 to 6, status 1 takes start-of-frame at bit c-1, end-of-frame at bit c+7 and branch at bit c+15. Each event is masked by the control-5 bit at the same position.
- R5: An unmasked frame event, or any bus error, that arrives while `irq` is low loads that channel's frame ID into the interrupt-ID register. If several channels report in the same cycle, the lowest-numbered channel wins.
- R6: The same events arriving while `irq` is high set status-0 bit 10 and leave the interrupt-ID register unchanged.
- R7: A masked frame event still sets its status bit, but it neither loads the ID nor sets bit 10.
- R8: A bus error sets status-0 bit 2 and writes the channel number into bits 30:28. It does this regardless of all masks, and bit 2 does not drive `irq`. Writing status 0 with bit 2 set clears both bit 2 and the channel field.
- R9: Writing status 0 clears the bits written as 1 within bits 11:0. Writing status 1 clears the bits written as 1 under 0x003E3F3F. An event that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R10: A control-0 write that changes bit 0 (enable) from 1 to 0 sets status-0 bit 7 (quick-disable done).
- R11: A `frame_end` pulse while control-0 bit 0 and bit 10 (disable) are both set clears bit 0 and sets status-0 bit 0. Without bit 10 set, the pulse changes nothing.
- R12: Underrun input 0 sets status-0 bit 4, masked by control-0 bit 5. Underrun input 1 sets status-0 bit 5, masked by control-5 bit 24.
- R13: Control-0 writes keep only the bits under 0x07FFFFFF. Control-5 writes keep only the bits under 0x3F3F3F3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| sof_evt | input | NCH | Start-of-frame pulse per channel |
| eof_evt | input | NCH | End-of-frame pulse per channel |
| bra_evt | input | NCH | Branch-taken pulse per channel |
| sof_int_en | input | NCH | Current command enables start-of-frame reporting |
| eof_int_en | input | NCH | Current command enables end-of-frame reporting |
| chan_id | input | NCH*IDW | Current frame ID per channel, channel 0 in the low slice |
| ber_evt | input | 1 | Bus error pulse |
| ber_ch | input | 3 | Channel of the bus error |
| urun_evt | input | 2 | Input underrun pulses for channels 0 and 1 |
| frame_end | input | 1 | End of a displayed frame |
| irq | output | 1 | Level interrupt |

## Verification
Channel 0 and channel 3 events are applied both one at a time and together. This separates the status-0 placement from the per-channel status-1 formula. It also shows whether the command enables gate only start and end of frame. Simultaneous events on several channels show the lowest-channel priority of the ID capture. Events applied while the line is already high separate ID capture from the second-interrupt flag. Mask-then-unmask sequences, bus errors under full masking, clears that collide with events, and the non-clearable branch bit of channel 1 show the mask routing and the clear rules.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

  typedef enum logic [2:0] {
    REG_CTRL0 = 3'd0,
    REG_CTRL5 = 3'd1,
    REG_STAT0 = 3'd2,
    REG_STAT1 = 3'd3,
    REG_IRQID = 3'd4
  } dirq_reg_e;

  // status 0 positions
  localparam int unsigned S0_LFD   = 0;
  localparam int unsigned S0_SOF   = 1;
  localparam int unsigned S0_BER   = 2;
  localparam int unsigned S0_IU0   = 4;
  localparam int unsigned S0_IU1   = 5;
  localparam int unsigned S0_OU    = 6;
  localparam int unsigned S0_QD    = 7;
  localparam int unsigned S0_EOF   = 8;
  localparam int unsigned S0_BRA   = 9;
  localparam int unsigned S0_SINT  = 10;
  localparam int unsigned S0_RDST  = 11;
  localparam int unsigned S0_CMD   = 12;
  localparam int unsigned S0_BCH   = 28;

  // control 0 positions
  localparam int unsigned C0_EN    = 0;
  localparam int unsigned C0_LFDM  = 3;
  localparam int unsigned C0_SOFM  = 4;
  localparam int unsigned C0_IU0M  = 5;
  localparam int unsigned C0_EOFM  = 6;
  localparam int unsigned C0_DIS   = 10;
  localparam int unsigned C0_QDM   = 11;
  localparam int unsigned C0_BRAM  = 20;
  localparam int unsigned C0_OUM   = 21;
  localparam int unsigned C0_RDM   = 23;
  localparam int unsigned C0_CMDM  = 24;

  // control 5 position for channel 1 underrun mask
  localparam int unsigned C5_IU1M  = 24;

  // status 1 offsets, added to the channel number
  localparam int S1_SOF_OFS = -1;
  localparam int S1_EOF_OFS = 7;
  localparam int S1_BRA_OFS = 15;

  localparam logic [31:0] C0_KEEP  = 32'h07FF_FFFF;
  localparam logic [31:0] C5_KEEP  = 32'h3F3F_3F3F;
  localparam logic [31:0] S0_CLRM  = 32'h0000_0FFF;
  localparam logic [31:0] S1_CLRM  = 32'h003E_3F3F;
  localparam logic [31:0] BCH_MASK = 32'h7000_0000;

endpackage

// File: rtl/dirq_chan_map.sv
// Places each channel's frame events into the status words and flags the
// channels whose events take part in ID capture / second-interrupt.
module dirq_chan_map
  import dirq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic [NCH-1:0] sof_evt,
  input  logic [NCH-1:0] eof_evt,
  input  logic [NCH-1:0] bra_evt,
  input  logic [NCH-1:0] sof_int_en,
  input  logic [NCH-1:0] eof_int_en,
  input  logic           ber_evt,
  input  logic [2:0]     ber_ch,
  input  logic [31:0]    s0_msk,
  input  logic [31:0]    ctrl5_q,
  output logic [31:0]    s0_set,
  output logic [31:0]    s1_set,
  output logic [NCH-1:0] notify
);

  logic [31:0] s0_part [NCH];
  logic [31:0] s1_part [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sof_ok, eof_ok;
    assign sof_ok = sof_evt[g] & sof_int_en[g];
    assign eof_ok = eof_evt[g] & eof_int_en[g];
    if (g == 0) begin : g_base
      assign s0_part[g] = (32'(sof_ok) << S0_SOF) |
                          (32'(eof_ok) << S0_EOF) |
                          (32'(bra_evt[g]) << S0_BRA);
      assign s1_part[g] = '0;
    end else begin : g_ext
      localparam int unsigned P_SOF = g + S1_SOF_OFS;
      localparam int unsigned P_EOF = g + S1_EOF_OFS;
      localparam int unsigned P_BRA = g + S1_BRA_OFS;
      assign s0_part[g] = '0;
      assign s1_part[g] = (32'(sof_ok) << P_SOF) |
                          (32'(eof_ok) << P_EOF) |
                          (32'(bra_evt[g]) << P_BRA);
    end
    assign notify[g] = (|(s0_part[g] & ~s0_msk)) |
                       (|(s1_part[g] & ~ctrl5_q)) |
                       (ber_evt && (ber_ch == 3'(g)));
  end

  always_comb begin
    s0_set = '0;
    s1_set = '0;
    for (int i = 0; i < NCH; i++) begin
      s0_set = s0_set | s0_part[i];
      s1_set = s1_set | s1_part[i];
    end
  end

endmodule

// File: rtl/dirq_id_pick.sv
// Lowest-numbered notifying channel supplies the frame ID.
module dirq_id_pick #(
  parameter int unsigned NCH = 7,
  parameter int unsigned IDW = 32
) (
  input  logic [NCH-1:0]     notify,
  input  logic [NCH*IDW-1:0] chan_id,
  output logic               any_notify,
  output logic [IDW-1:0]     pick_id
);

  always_comb begin
    any_notify = |notify;
    pick_id    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (notify[i]) pick_id = chan_id[i*IDW +: IDW];
    end
  end

endmodule

// File: rtl/dirq_status_regs.sv
module dirq_status_regs
  import dirq_pkg::*;
#(
  parameter int unsigned IDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [31:0]    wr_data,
  input  logic [31:0]    s0_set,
  input  logic [31:0]    s1_set,
  input  logic [31:0]    s0_msk,
  input  logic           ber_evt,
  input  logic [2:0]     ber_ch,
  input  logic [1:0]     urun_evt,
  input  logic           frame_end,
  input  logic           any_notify,
  input  logic [IDW-1:0] pick_id,
  output logic [31:0]    ctrl0_q,
  output logic [31:0]    ctrl5_q,
  output logic [31:0]    stat0_q,
  output logic [31:0]    stat1_q,
  output logic [IDW-1:0] irqid_q,
  output logic           irq_q
);

  logic        hit_c0, hit_c5, hit_s0, hit_s1;
  logic        end_dis, qd_hit;
  logic        ctrl0_en, ctrl5_en, id_en;
  logic [31:0] ctrl0_d, ctrl5_d, stat0_d, stat1_d;
  logic [31:0] s0_clr, s1_clr, s0_add;
  logic        irq_d;

  always_comb begin
    hit_c0 = wr_en && (wr_sel == REG_CTRL0);
    hit_c5 = wr_en && (wr_sel == REG_CTRL5);
    hit_s0 = wr_en && (wr_sel == REG_STAT0);
    hit_s1 = wr_en && (wr_sel == REG_STAT1);

    end_dis = frame_end & ctrl0_q[C0_EN] & ctrl0_q[C0_DIS];
    qd_hit  = hit_c0 & ctrl0_q[C0_EN] & ~wr_data[C0_EN];

    ctrl0_en = hit_c0 | end_dis;
    if (hit_c0) ctrl0_d = wr_data & C0_KEEP;
    else        ctrl0_d = ctrl0_q & ~(32'(1) << C0_EN);

    ctrl5_en = hit_c5;
    ctrl5_d  = wr_data & C5_KEEP;

    s0_clr = '0;
    if (hit_s0) begin
      s0_clr = wr_data & S0_CLRM;
      if (wr_data[S0_BER]) s0_clr = s0_clr | BCH_MASK;
    end
    s1_clr = hit_s1 ? (wr_data & S1_CLRM) : '0;

    s0_add = s0_set
           | (32'(urun_evt[0]) << S0_IU0)
           | (32'(urun_evt[1]) << S0_IU1)
           | (32'(end_dis) << S0_LFD)
           | (32'(qd_hit) << S0_QD)
           | (32'(ber_evt) << S0_BER)
           | (32'(any_notify & irq_q) << S0_SINT);

    stat0_d = (stat0_q & ~s0_clr) | s0_add;
    if (ber_evt) stat0_d[S0_BCH +: 3] = ber_ch;
    stat1_d = (stat1_q & ~s1_clr) | s1_set;

    id_en = any_notify & ~irq_q;

    irq_d = (|(stat0_q & ~s0_msk)) | (|(stat1_q & ~ctrl5_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl5_q <= '0;
      stat0_q <= '0;
      stat1_q <= '0;
      irqid_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl0_en) ctrl0_q <= ctrl0_d;
      if (ctrl5_en) ctrl5_q <= ctrl5_d;
      stat0_q <= stat0_d;
      stat1_q <= stat1_d;
      if (id_en) irqid_q <= pick_id;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/dirq_aggregator.sv
module dirq_aggregator
  import dirq_pkg::*;
#(
  parameter int unsigned NCH = 7,   // at most 7: 3-bit channel field
  parameter int unsigned IDW = 32   // at most 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [31:0]        wr_data,
  input  logic [2:0]         rd_sel,
  output logic [31:0]        rd_data,
  input  logic [NCH-1:0]     sof_evt,
  input  logic [NCH-1:0]     eof_evt,
  input  logic [NCH-1:0]     bra_evt,
  input  logic [NCH-1:0]     sof_int_en,
  input  logic [NCH-1:0]     eof_int_en,
  input  logic [NCH*IDW-1:0] chan_id,
  input  logic               ber_evt,
  input  logic [2:0]         ber_ch,
  input  logic [1:0]         urun_evt,
  input  logic               frame_end,
  output logic               irq
);

  logic [1:0]     rst_sync;
  logic           rst_n_s;
  logic [31:0]    ctrl0_q, ctrl5_q, stat0_q, stat1_q;
  logic [IDW-1:0] irqid_q;
  logic [31:0]    s0_msk, s0_set, s1_set;
  logic [NCH-1:0] notify;
  logic           any_notify;
  logic [IDW-1:0] pick_id;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // mask image aligned to status 0; 1 = source does not reach irq
  always_comb begin
    s0_msk          = '1;
    s0_msk[S0_LFD]  = ctrl0_q[C0_LFDM];
    s0_msk[S0_SOF]  = ctrl0_q[C0_SOFM];
    s0_msk[S0_IU0]  = ctrl0_q[C0_IU0M];
    s0_msk[S0_IU1]  = ctrl5_q[C5_IU1M];
    s0_msk[S0_OU]   = ctrl0_q[C0_OUM];
    s0_msk[S0_QD]   = ctrl0_q[C0_QDM];
    s0_msk[S0_EOF]  = ctrl0_q[C0_EOFM];
    s0_msk[S0_BRA]  = ctrl0_q[C0_BRAM];
    s0_msk[S0_RDST] = ctrl0_q[C0_RDM];
    s0_msk[S0_CMD]  = ctrl0_q[C0_CMDM];
  end

  dirq_chan_map #(.NCH(NCH)) u_map (
    .sof_evt    (sof_evt),
    .eof_evt    (eof_evt),
    .bra_evt    (bra_evt),
    .sof_int_en (sof_int_en),
    .eof_int_en (eof_int_en),
    .ber_evt    (ber_evt),
    .ber_ch     (ber_ch),
    .s0_msk     (s0_msk),
    .ctrl5_q    (ctrl5_q),
    .s0_set     (s0_set),
    .s1_set     (s1_set),
    .notify     (notify)
  );

  dirq_id_pick #(.NCH(NCH), .IDW(IDW)) u_pick (
    .notify     (notify),
    .chan_id    (chan_id),
    .any_notify (any_notify),
    .pick_id    (pick_id)
  );

  dirq_status_regs #(.IDW(IDW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .s0_set     (s0_set),
    .s1_set     (s1_set),
    .s0_msk     (s0_msk),
    .ber_evt    (ber_evt),
    .ber_ch     (ber_ch),
    .urun_evt   (urun_evt),
    .frame_end  (frame_end),
    .any_notify (any_notify),
    .pick_id    (pick_id),
    .ctrl0_q    (ctrl0_q),
    .ctrl5_q    (ctrl5_q),
    .stat0_q    (stat0_q),
    .stat1_q    (stat1_q),
    .irqid_q    (irqid_q),
    .irq_q      (irq)
  );

  always_comb begin
    case (rd_sel)
      REG_CTRL0: rd_data = ctrl0_q;
      REG_CTRL5: rd_data = ctrl5_q;
      REG_STAT0: rd_data = stat0_q;
      REG_STAT1: rd_data = stat1_q;
      REG_IRQID: rd_data = 32'(irqid_q);
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker #(
  parameter int unsigned IDW = 32
) (
  input logic           clk,
  input logic           rst_n_s,
  input logic           wr_en,
  input logic [2:0]     wr_sel,
  input logic [31:0]    wr_data,
  input logic           ber_evt,
  input logic [2:0]     ber_ch,
  input logic           any_notify,
  input logic           irq,
  input logic [31:0]    stat0_q,
  input logic [31:0]    stat1_q,
  input logic [31:0]    ctrl5_q,
  input logic [31:0]    s0_msk,
  input logic [31:0]    s1_set,
  input logic [IDW-1:0] irqid_q
);

  // R2: nothing pending means the line drops
  p_quiet_irq_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stat0_q == 32'd0 && stat1_q == 32'd0) |=> !irq);

  // R2: an unmasked pending bit raises the line one clock later
  p_pending_irq_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((|(stat0_q & ~s0_msk)) || (|(stat1_q & ~ctrl5_q))) |=> irq);

  // R8: bus error records its channel
  p_ber_field_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ber_evt |=> (stat0_q[2] && stat0_q[30:28] == $past(ber_ch)));

  // R6: event while the line is high sets the second-interrupt flag
  p_sint_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (any_notify && irq) |=> stat0_q[10]);

  // R5: the ID only moves on a notifying event while the line is low
  p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!any_notify || irq) |=> $stable(irqid_q));

  // R9: status 1 write-one-clear
  p_s1_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == 3'd3 && s1_set == 32'd0) |=>
      ((stat1_q & $past(wr_data) & 32'h003E_3F3F) == 32'd0));

endmodule

bind dirq_aggregator dirq_checker #(.IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .ber_evt    (ber_evt),
  .ber_ch     (ber_ch),
  .any_notify (any_notify),
  .irq        (irq),
  .stat0_q    (stat0_q),
  .stat1_q    (stat1_q),
  .ctrl5_q    (ctrl5_q),
  .s0_msk     (s0_msk),
  .s1_set     (s1_set),
  .irqid_q    (irqid_q)
);

// File: tb/tb_dirq_aggregator.sv
module tb_dirq_aggregator;

  localparam int unsigned NCH = 7;
  localparam int unsigned IDW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [2:0]         wr_sel;
  logic [31:0]        wr_data;
  logic [2:0]         rd_sel;
  logic [31:0]        rd_data;
  logic [NCH-1:0]     sof_evt, eof_evt, bra_evt, sof_int_en, eof_int_en;
  logic [NCH*IDW-1:0] chan_id;
  logic               ber_evt;
  logic [2:0]         ber_ch;
  logic [1:0]         urun_evt;
  logic               frame_end;
  logic               irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirq_aggregator #(.NCH(NCH), .IDW(IDW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sof_evt(sof_evt), .eof_evt(eof_evt),
    .bra_evt(bra_evt), .sof_int_en(sof_int_en), .eof_int_en(eof_int_en),
    .chan_id(chan_id), .ber_evt(ber_evt), .ber_ch(ber_ch), .urun_evt(urun_evt),
    .frame_end(frame_end), .irq(irq)
  );

  function automatic logic [31:0] idof(input int c);
    return 32'hA000_0000 + 32'(c);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    sof_evt = 0; eof_evt = 0; bra_evt = 0;
    ber_evt = 0; ber_ch = 0; urun_evt = 0; frame_end = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic fire(input logic [NCH-1:0] s, input logic [NCH-1:0] e, input logic [NCH-1:0] b);
    sof_evt = s; eof_evt = e; bra_evt = b;
    @(negedge clk);
    sof_evt = 0; eof_evt = 0; bra_evt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctrl0", 3'd0, 0); chk_reg("R1 ctrl0", 3'd0, 0);
    chk_reg("R1 ctrl5", 3'd1, 0);
    chk_reg("R1 stat0", 3'd2, 0);
    chk_reg("R1 stat1", 3'd3, 0);
    chk_reg("R1 irqid", 3'd4, 0);
    chk_reg("R1 unused select", 3'd7, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_ch0();
    do_reset();
    fire(7'h01, 7'h00, 7'h00);
    chk_reg("R3 sof0 bit", 3'd2, 32'h2);
    chk_reg("R5 id capture ch0", 3'd4, idof(0));
    chk("R2 irq still low same cycle", 32'(irq), 0);
    tick();
    chk("R2 irq high one clock later", 32'(irq), 1);
    fire(7'h00, 7'h01, 7'h00);
    chk_reg("R6 eof0 + second interrupt", 3'd2, 32'h502);
    chk_reg("R6 id kept", 3'd4, idof(0));
    fire(7'h00, 7'h00, 7'h01);
    chk_reg("R3 branch0 bit9", 3'd2, 32'h702);
    reg_wr(3'd2, 32'hFFF);
    chk_reg("R9 stat0 clear", 3'd2, 0);
    tick();
    chk("R2 irq drops", 32'(irq), 0);
    // command enables gate start/end of frame
    sof_int_en = '0; eof_int_en = '0;
    fire(7'h01, 7'h01, 7'h00);
    chk_reg("R3 gated sof/eof", 3'd2, 0);
    chk_reg("R3 gated no id change", 3'd4, idof(0));
    sof_int_en = '1; eof_int_en = '1;
  endtask

  task automatic t_chan_pos();
    do_reset();
    fire(7'h08, 7'h08, 7'h08);
    chk_reg("R4 ch3 positions", 3'd3, 32'h0004_0404);
    chk_reg("R5 id ch3", 3'd4, idof(3));
    tick();
    chk("R2 irq from stat1", 32'(irq), 1);
    do_reset();
    fire(7'h24, 7'h00, 7'h40);
    chk_reg("R4 ch2 ch5 ch6 positions", 3'd3, 32'h0020_0012);
    chk_reg("R5 lowest channel wins", 3'd4, idof(2));
    chk_reg("R6 no sint when low", 3'd2, 0);
  endtask

  task automatic t_mask();
    do_reset();
    reg_wr(3'd1, 32'h4);
    fire(7'h08, 7'h00, 7'h00);
    chk_reg("R7 masked bit still set", 3'd3, 32'h4);
    chk_reg("R7 masked no id", 3'd4, 0);
    tick();
    chk("R7 masked no irq", 32'(irq), 0);
    chk_reg("R7 masked no sint", 3'd2, 0);
    reg_wr(3'd1, 32'h0);
    chk("R2 unmask not yet", 32'(irq), 0);
    tick();
    chk("R2 unmask raises irq", 32'(irq), 1);
    do_reset();
    reg_wr(3'd0, 32'h10);
    fire(7'h01, 7'h00, 7'h00);
    chk_reg("R7 ch0 masked bit", 3'd2, 32'h2);
    chk_reg("R7 ch0 masked no id", 3'd4, 0);
    tick();
    chk("R7 ch0 masked no irq", 32'(irq), 0);
  endtask

  task automatic t_ber();
    do_reset();
    reg_wr(3'd0, 32'h07FF_FFF0);
    reg_wr(3'd1, 32'h3F3F_3F3F);
    ber_evt = 1; ber_ch = 3'd5;
    tick();
    ber_evt = 0;
    chk_reg("R8 ber bit and channel", 3'd2, 32'h5000_0004);
    chk_reg("R8 id captured under masks", 3'd4, idof(5));
    tick();
    chk("R8 ber not an irq source", 32'(irq), 0);
    ber_evt = 1; ber_ch = 3'd2;
    tick();
    ber_evt = 0;
    chk_reg("R8 channel replaced", 3'd2, 32'h2000_0004);
    chk_reg("R8 id from second ber", 3'd4, idof(2));
    reg_wr(3'd2, 32'h4);
    chk_reg("R8 clear drops field", 3'd2, 0);
  endtask

  task automatic t_clear();
    do_reset();
    wr_en = 1; wr_sel = 3'd2; wr_data = 32'h2; sof_evt = 7'h01;
    tick();
    wr_en = 0; wr_data = 0; sof_evt = 0;
    chk_reg("R9 set wins over clear", 3'd2, 32'h2);
    do_reset();
    fire(7'h02, 7'h02, 7'h02);
    chk_reg("R4 ch1 positions", 3'd3, 32'h0001_0101);
    reg_wr(3'd3, 32'hFFFF_FFFF);
    chk_reg("R9 stat1 clear mask", 3'd3, 32'h0001_0000);
  endtask

  task automatic t_qd();
    do_reset();
    reg_wr(3'd0, 32'h1);
    chk_reg("R10 enable alone no qd", 3'd2, 0);
    reg_wr(3'd0, 32'h0);
    chk_reg("R10 quick disable", 3'd2, 32'h80);
    tick();
    chk("R10 qd raises irq", 32'(irq), 1);
  endtask

  task automatic t_lfd();
    do_reset();
    reg_wr(3'd0, 32'h1);
    frame_end = 1; tick(); frame_end = 0;
    chk_reg("R11 no disable keeps enable", 3'd0, 32'h1);
    chk_reg("R11 no disable no status", 3'd2, 0);
    reg_wr(3'd0, 32'h401);
    frame_end = 1; tick(); frame_end = 0;
    chk_reg("R11 enable cleared", 3'd0, 32'h400);
    chk_reg("R11 last frame done", 3'd2, 32'h1);
  endtask

  task automatic t_urun();
    do_reset();
    urun_evt = 2'b01; tick(); urun_evt = 0;
    chk_reg("R12 underrun 0", 3'd2, 32'h10);
    tick();
    chk("R12 underrun 0 irq", 32'(irq), 1);
    do_reset();
    reg_wr(3'd1, 32'h0100_0000);
    urun_evt = 2'b10; tick(); urun_evt = 0;
    chk_reg("R12 underrun 1", 3'd2, 32'h20);
    tick();
    chk("R12 underrun 1 masked by ctrl5", 32'(irq), 0);
  endtask

  task automatic t_keep();
    do_reset();
    reg_wr(3'd0, 32'hFFFF_FFFF);
    chk_reg("R13 ctrl0 keep", 3'd0, 32'h07FF_FFFF);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    chk_reg("R13 ctrl5 keep", 3'd1, 32'h3F3F_3F3F);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) chan_id[c*IDW +: IDW] = idof(c);
    sof_int_en = '1;
    eof_int_en = '1;
    rd_sel = 0;
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_ch0();
    t_chan_pos();
    t_mask();
    t_ber();
    t_clear();
    t_qd();
    t_lfd();
    t_urun();
    t_keep();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..R13 run incomplete): actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule